// File: doc/BRIEF.md
# Coefficient Memory Checksum Scrubber

This block guards a small on-chip store of filter and calibration constants against single-event upsets. When reset is released it accepts the constants as a stream from non-volatile storage and writes them into the external coefficient memory in address order. While the words stream in, it forms a 16-bit one's-complement sum over them and keeps that sum as the reference.

After the load it re-reads the whole memory in the background, again and again. A scrub read goes out only on cycles when the DSP datapath is not reading the memory, so the datapath never waits. Each finished pass produces a new sum, which is compared with the reference. A mismatch sets a sticky error bit and raises `fault`, which the system uses to enter its fault state. Each pass is timed in millisecond ticks against a programmable limit, so a pass that runs too long, for example because the datapath starves the scrubber, is flagged.

The load stream uses valid/ready. A word moves on a rising edge where `ld_valid` and `ld_ready` are both high. The source keeps `ld_valid` and `ld_data` steady until that edge and may leave gaps of any length between words. The block holds `ld_ready` high from reset until the last word has been taken, then drops it and leaves it low until the next reset. The memory read port has a latency of one cycle: `mem_rd_data` carries the word addressed by the read enabled on the previous edge.

Top module: `coef_scrub_top`

## Requirements
- R1: After reset `ld_ready` is high. Each accepted load word drives `mem_we` in its handshake cycle, with `mem_waddr` counting 0, 1, ... DEPTH-1 and `mem_wdata` equal to `ld_data`. `ld_ready` goes low after word DEPTH-1 and stays low.
- R2: Register address 2 reads the reference, which is the 16-bit one's-complement sum (end-around carry, accumulator starting at 0) of the loaded words in load order. Status bit 0 reads 1 once the load is complete.
- R3: While `dsp_rd_en` is high, `mem_rd_en` is high and `mem_rd_addr` equals `dsp_rd_addr`. Scrub reads are issued only in cycles where `dsp_rd_en` is low.
- R4: Register address 3 reads the checksum of the most recent completed pass, computed over the memory contents in the same way as R2.
- R5: A pass checksum that differs from the reference sets status bit 1 and drives `fault` high.
- R6: Status bit 1 and `fault` are sticky. A write of 0 to that bit, or a memory that later matches again, leaves them set. Writing 1 to bit 1 of address 0 clears them.
- R7: Millisecond ticks are counted from the start of each pass. When the count reaches the limit in address 1 before the pass ends, status bit 2 is set. A limit of 0 disables the check. The limit resets to LIMIT_DEFAULT (99).
- R8: Status bit 2 is sticky and clears when 1 is written to bit 2 of address 0.
- R9: Reset leaves `fault` low and status bits 1 and 2 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_valid | input | 1 | Load stream word valid |
| ld_ready | output | 1 | Load stream ready |
| ld_data | input | DATA_W | Load stream word |
| mem_we | output | 1 | Memory write enable |
| mem_waddr | output | AW | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rd_en | output | 1 | Memory read enable |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DATA_W | Memory read data, one cycle after enable |
| dsp_rd_en | input | 1 | DSP datapath read request |
| dsp_rd_addr | input | AW | DSP datapath read address |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 limit, 2 reference, 3 last pass sum |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| fault | output | 1 | Checksum fault |

## Verification
The load is driven with irregular gaps between words. The constants are chosen so that their sum wraps past 16 bits many times. This separates a true end-around-carry sum from a plain truncated add, and a scoreboard checks that gaps neither drop nor repeat a memory write. The memory is then left alone so that clean passes match the reference. One upset is injected into a single word: the mismatch, the sticky fault and the new pass sum show that the memory is really re-read and not served from a copy. Holding the DSP read line starves the scrubber. With limits of 2 and 0 this separates a deadline that fires exactly at the limit from one that is disabled. Ticks spaced far apart under normal traffic show that the count restarts with every pass.

// File: rtl/coef_scrub_pkg.sv
package coef_scrub_pkg;
  // register map (two-bit address)
  localparam logic [1:0] RA_STATUS = 2'd0;
  localparam logic [1:0] RA_LIMIT  = 2'd1;
  localparam logic [1:0] RA_REF    = 2'd2;
  localparam logic [1:0] RA_PASS   = 2'd3;

  // status bit positions; bit 1 feeds the system fault state
  localparam int ST_LOADED = 0;
  localparam int ST_CSUM   = 1;
  localparam int ST_LATE   = 2;
endpackage

// File: rtl/scrub_load.sv
module scrub_load #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 16,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  output logic              ld_ready,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              word_fire,
  output logic              word_last,
  output logic              load_done
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr;

  assign ld_ready  = !load_done;
  assign word_fire = ld_valid && ld_ready;
  assign word_last = word_fire && (wr_ptr == LAST_ADDR);
  assign mem_we    = word_fire;
  assign mem_waddr = wr_ptr;
  assign mem_wdata = ld_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      load_done <= 1'b0;
    end else if (word_fire) begin
      wr_ptr <= wr_ptr + AW'(1);
      if (word_last) load_done <= 1'b1;
    end
  end
endmodule

// File: rtl/scrub_reader.sv
module scrub_reader #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          dsp_rd_en,
  input  logic [AW-1:0] dsp_rd_addr,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  output logic          word_valid,
  output logic          word_last
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic          issue;
  logic [AW-1:0] scan_ptr;

  // the datapath always wins the port; scrub only fills idle cycles
  assign issue       = enable && !dsp_rd_en;
  assign mem_rd_en   = dsp_rd_en || issue;
  assign mem_rd_addr = dsp_rd_en ? dsp_rd_addr : scan_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_ptr   <= '0;
      word_valid <= 1'b0;
      word_last  <= 1'b0;
    end else begin
      word_valid <= issue;
      word_last  <= issue && (scan_ptr == LAST_ADDR);
      if (issue) scan_ptr <= (scan_ptr == LAST_ADDR) ? '0 : scan_ptr + AW'(1);
    end
  end
endmodule

// File: rtl/csum_acc.sv
module csum_acc #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              add_en,
  input  logic              add_last,
  input  logic [DATA_W-1:0] add_data,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] acc;
  logic [DATA_W:0]   raw;
  logic [DATA_W-1:0] folded;

  // one's-complement add: carry out wraps back into bit 0
  always_comb begin
    raw    = {1'b0, acc} + {1'b0, add_data};
    folded = raw[DATA_W-1:0] + {{(DATA_W-1){1'b0}}, raw[DATA_W]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= add_en && add_last;
      if (add_en) begin
        if (add_last) begin
          acc    <= '0;
          result <= folded;
        end else begin
          acc <= folded;
        end
      end
    end
  end
endmodule

// File: rtl/scrub_deadline.sv
module scrub_deadline #(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             ms_tick,
  input  logic             pass_done,
  input  logic [LIM_W-1:0] limit,
  output logic             miss
);
  localparam logic [LIM_W-1:0] CNT_MAX = '1;

  logic [LIM_W-1:0] ms_cnt;
  logic [LIM_W-1:0] cnt_inc;

  assign cnt_inc = ms_cnt + LIM_W'(1);
  assign miss    = active && ms_tick && !pass_done && (limit != '0)
                   && (ms_cnt != CNT_MAX) && (cnt_inc == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ms_cnt <= '0;
    end else if (pass_done) begin
      ms_cnt <= '0;
    end else if (active && ms_tick && ms_cnt != CNT_MAX) begin
      ms_cnt <= cnt_inc;
    end
  end
endmodule

// File: rtl/coef_scrub_top.sv
module coef_scrub_top
  import coef_scrub_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int DATA_W        = 16,
  parameter int LIM_W         = 8,
  parameter int LIMIT_DEFAULT = 99,
  localparam int AW           = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [DATA_W-1:0] ld_data,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              dsp_rd_en,
  input  logic [AW-1:0]     dsp_rd_addr,
  input  logic              ms_tick,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              fault
);
  logic              ld_fire, ld_last, loaded;
  logic              rd_valid, rd_last;
  logic              add_en, add_last;
  logic [DATA_W-1:0] add_data;
  logic              acc_done;
  logic [DATA_W-1:0] acc_result;
  logic              ref_valid, pass_done, miss;
  logic [DATA_W-1:0] ref_q, pass_q;
  logic              csum_err, late;
  logic [LIM_W-1:0]  limit_q;
  logic              wr_status, wr_limit;
  logic              unused_wdata;

  scrub_load #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) u_load (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
    .ld_ready(ld_ready), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .word_fire(ld_fire), .word_last(ld_last),
    .load_done(loaded)
  );

  scrub_reader #(.DEPTH(DEPTH), .AW(AW)) u_reader (
    .clk(clk), .rst_n(rst_n), .enable(loaded), .dsp_rd_en(dsp_rd_en),
    .dsp_rd_addr(dsp_rd_addr), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .word_valid(rd_valid), .word_last(rd_last)
  );

  // one accumulator serves the load (reference) and every later pass
  assign add_en   = loaded ? rd_valid : ld_fire;
  assign add_last = loaded ? rd_last  : ld_last;
  assign add_data = loaded ? mem_rd_data : ld_data;

  csum_acc #(.DATA_W(DATA_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .add_en(add_en), .add_last(add_last),
    .add_data(add_data), .done(acc_done), .result(acc_result)
  );

  assign pass_done = acc_done && ref_valid;

  scrub_deadline #(.LIM_W(LIM_W)) u_deadline (
    .clk(clk), .rst_n(rst_n), .active(ref_valid), .ms_tick(ms_tick),
    .pass_done(pass_done), .limit(limit_q), .miss(miss)
  );

  assign wr_status    = reg_wr && (reg_addr == RA_STATUS);
  assign wr_limit     = reg_wr && (reg_addr == RA_LIMIT);
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q     <= '0;
      ref_valid <= 1'b0;
      pass_q    <= '0;
      csum_err  <= 1'b0;
      late      <= 1'b0;
      limit_q   <= LIM_W'(LIMIT_DEFAULT);
    end else begin
      if (acc_done && !ref_valid) begin
        ref_q     <= acc_result;
        ref_valid <= 1'b1;
      end
      if (pass_done) pass_q <= acc_result;
      // a new mismatch outranks a simultaneous clear
      if (pass_done && acc_result != ref_q) csum_err <= 1'b1;
      else if (wr_status && reg_wdata[ST_CSUM]) csum_err <= 1'b0;
      if (miss) late <= 1'b1;
      else if (wr_status && reg_wdata[ST_LATE]) late <= 1'b0;
      if (wr_limit) limit_q <= reg_wdata[LIM_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_STATUS: begin
        reg_rdata[ST_LOADED] = loaded;
        reg_rdata[ST_CSUM]   = csum_err;
        reg_rdata[ST_LATE]   = late;
      end
      RA_LIMIT: reg_rdata = DATA_W'(limit_q);
      RA_REF:   reg_rdata = ref_q;
      default:  reg_rdata = pass_q;
    endcase
  end

  assign fault = csum_err;
endmodule

// File: rtl/coef_scrub_chk.sv
module coef_scrub_chk #(
  parameter int DATA_W = 16,
  parameter int AW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic              mem_we,
  input logic              mem_rd_en,
  input logic [AW-1:0]     mem_rd_addr,
  input logic              dsp_rd_en,
  input logic [AW-1:0]     dsp_rd_addr,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              fault
);
  assert_write_on_handshake_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ld_valid && ld_ready));

  assert_ready_stays_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ready |=> !ld_ready);

  assert_dsp_owns_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_rd_en |-> (mem_rd_en && mem_rd_addr == dsp_rd_addr));

  assert_fault_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !ld_ready);

  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !(reg_wr && reg_addr == 2'd0 && reg_wdata[1])) |=> fault);
endmodule

bind coef_scrub_top coef_scrub_chk #(.DATA_W(DATA_W), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .mem_we(mem_we), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
  .dsp_rd_en(dsp_rd_en), .dsp_rd_addr(dsp_rd_addr), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .fault(fault)
);

// File: tb/coef_scrub_top_tb_top.sv
`timescale 1ns/1ps
module coef_scrub_top_tb_top;
  localparam int DEPTH = 16;
  localparam int W     = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [W-1:0]  ld_data = '0;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [W-1:0]  mem_wdata;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [W-1:0]  mem_rd_data;
  logic          dsp_rd_en = 1'b0;
  logic [AW-1:0] dsp_rd_addr = '0;
  logic          ms_tick = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [W-1:0]  reg_wdata = '0;
  logic [W-1:0]  reg_rdata;
  logic          fault;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [W-1:0]      words [DEPTH];
  logic [W-1:0]      mem_model [DEPTH];
  logic [AW+W-1:0]   exp_q [$];
  logic              seu_go = 1'b0;
  logic [AW-1:0]     seu_addr = '0;
  logic [W-1:0]      seu_mask = '0;

  always #4 clk = ~clk;

  coef_scrub_top dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_data(ld_data), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .dsp_rd_en(dsp_rd_en), .dsp_rd_addr(dsp_rd_addr),
    .ms_tick(ms_tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fault(fault)
  );

  // memory model: synchronous write, one-cycle read; also injects upsets
  always @(posedge clk) begin
    if (mem_we) mem_model[mem_waddr] <= mem_wdata;
    if (seu_go) mem_model[seu_addr] <= mem_model[seu_addr] ^ seu_mask;
    if (mem_rd_en) mem_rd_data <= mem_model[mem_rd_addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every memory write must match the next queued item
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) chk("R1 unexpected write", {16'h0, AW'(mem_waddr), mem_wdata}, 32'hFFFF_FFFF);
      else chk("R1 load write", {12'h0, mem_waddr, mem_wdata}, {12'h0, exp_q.pop_front()});
    end
  end

  function automatic logic [W-1:0] ocsum(input logic [W-1:0] a [DEPTH]);
    logic [W:0] s;
    logic [W-1:0] acc = '0;
    for (int i = 0; i < DEPTH; i++) begin
      s = {1'b0, acc} + {1'b0, a[i]};
      acc = s[W-1:0] + {{(W-1){1'b0}}, s[W]};
    end
    return acc;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] v);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
    step();
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic tick();
    ms_tick = 1'b1; step(); ms_tick = 1'b0; step();
  endtask

  task automatic push_word(input int i);
    bit hs;
    ld_valid = 1'b1; ld_data = words[i];
    exp_q.push_back({AW'(i), words[i]});
    do begin
      @(negedge clk); hs = ld_ready;
      step();
    end while (!hs);
    ld_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    logic [W-1:0] ref_sum, bad_sum;
    logic [W-1:0] bad [DEPTH];
    for (int i = 0; i < DEPTH; i++) words[i] = 16'hF000 + 16'(i * 16'h1357);
    ref_sum = ocsum(words);
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // reset state
    @(negedge clk);
    chk("R9 fault after reset", fault, 0);
    chk("R1 ready after reset", ld_ready, 1);
    step();
    rd(2'd0, v); chk("R9 status after reset", v, 0);
    rd(2'd1, v); chk("R7 default limit", v, 99);

    // load with irregular gaps
    for (int i = 0; i < DEPTH; i++) begin
      if (i % 3 == 1) repeat (i % 4 + 1) step();
      push_word(i);
    end
    step();
    @(negedge clk); chk("R1 ready low after load", ld_ready, 0);
    chk("R1 all writes seen", exp_q.size(), 0);
    step();
    rd(2'd0, v); chk("R2 loaded bit", v[0], 1);
    rd(2'd2, v); chk("R2 reference sum", v, ref_sum);

    // clean passes
    repeat (80) step();
    rd(2'd3, v); chk("R4 clean pass sum", v, ref_sum);
    rd(2'd0, v); chk("R5 no error on clean memory", v[2:1], 0);

    // datapath owns the port
    dsp_rd_en = 1'b1; dsp_rd_addr = 4'd5;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R3 dsp read forwarded", {mem_rd_en, 3'b0, mem_rd_addr}, {1'b1, 3'b0, 4'd5});
      step();
    end

    // deadline, still starving the scrubber
    wr(2'd1, 16'd2);
    tick();
    rd(2'd0, v); chk("R7 one tick below limit", v[2], 0);
    tick();
    rd(2'd0, v); chk("R7 deadline hit at limit", v[2], 1);
    wr(2'd0, 16'h0004);
    rd(2'd0, v); chk("R8 late bit cleared", v[2], 0);
    wr(2'd1, 16'd0);
    repeat (4) tick();
    rd(2'd0, v); chk("R7 limit zero disables", v[2], 0);
    dsp_rd_en = 1'b0;
    wr(2'd1, 16'd3);
    repeat (4) begin tick(); repeat (40) step(); end
    rd(2'd0, v); chk("R7 count restarts each pass", v[2], 0);

    // single-event upset on word 7
    for (int i = 0; i < DEPTH; i++) bad[i] = words[i];
    bad[7] = words[7] ^ 16'h0010;
    bad_sum = ocsum(bad);
    seu_addr = 4'd7; seu_mask = 16'h0010; seu_go = 1'b1; step(); seu_go = 1'b0;
    repeat (80) step();
    @(negedge clk); chk("R5 fault raised", fault, 1);
    step();
    rd(2'd0, v); chk("R5 status csum bit", v[1], 1);
    rd(2'd3, v); chk("R4 corrupted pass sum", v, bad_sum);
    wr(2'd0, 16'h0000);
    rd(2'd0, v); chk("R6 write zero keeps bit", v[1], 1);

    // repair memory: error must remain until cleared
    seu_go = 1'b1; step(); seu_go = 1'b0;
    repeat (80) step();
    rd(2'd3, v); chk("R4 repaired pass sum", v, ref_sum);
    @(negedge clk); chk("R6 fault sticky after repair", fault, 1);
    step();
    wr(2'd0, 16'h0002);
    repeat (60) step();
    @(negedge clk); chk("R6 fault cleared by write one", fault, 0);
    step();
    rd(2'd0, v); chk("R6 status bit cleared", v[1], 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule